// File: doc/BRIEF.md
# Programmable-Frame Line Decoder (Manchester / NRZ)

This block receives one serial line and turns it into framed values. Registers set how a frame is built: the line coding (Manchester or NRZ), the bit period in clock cycles, the direction of the edge that starts a frame, and the lengths of four sections. The sections are a run of synchronization bits, which are discarded, then a header field, a data field and a trailer field. Any of the three fields may have length zero.

Bits are assembled most-significant first. When the last bit of the frame arrives, the three field values appear together on the outputs with a one-cycle valid strobe. In Manchester mode every bit cell must carry a mid-cell transition inside a timing window. If that transition is missing or late, the frame is abandoned with a one-cycle error strobe. After a good frame or an error the decoder goes back to waiting for the next start edge.

The line input is expected to be synchronous to `clk`. Configuration inputs must stay constant while a frame is being received.

Top module: `lcd_frame_rx`

## Requirements
- R1: After synchronous reset, `frm_valid` and `frm_err` are 0 and all three field outputs are 0.
- R2: In NRZ mode (`cfg_manchester`=0) a bit cell lasts `cfg_baud_div` clocks (at least 4). The line is sampled in the middle of each cell, and fields are right-aligned with the first received bit as the most significant.
- R3: In Manchester mode (`cfg_manchester`=1) a falling transition at mid-cell decodes as 1 and a rising transition decodes as 0.
- R4: While idle, a frame starts only on a line edge whose new level equals `cfg_start_pol` (1 = rising, 0 = falling). An edge in the other direction starts nothing and produces neither strobe.
- R5: The first `cfg_sync_bits` bits (0 to 15) of a frame are consumed and appear in no field.
- R6: Header, data and trailer lengths are each 0 to 32 bits. A zero-length field is skipped and reads 0 in the completed frame. The layout of 2 sync bits, no header, a 10-bit data field and a 1-bit trailer is decoded correctly.
- R7: In Manchester mode, if no mid-cell transition arrives by T+T/4 clocks after the previous one (T/2+T/4 after the start edge for the first bit), then `frm_err` pulses once, no `frm_valid` is given for that frame, and the field outputs keep their previous values.
- R8: `frm_valid` is a single-cycle pulse. After `frm_valid` or `frm_err` the decoder is idle again, and the next start edge begins a new frame that decodes normally.
- R9: In Manchester mode, mid-cell transitions spaced anywhere from T−T/4 to T+T/4 clocks apart are accepted. Transitions at cell boundaries do not disturb decoding.
- R10: NRZ mode never raises `frm_err`, even on long runs of equal bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_manchester | input | 1 | 1 = Manchester coding, 0 = NRZ |
| cfg_baud_div | input | 16 | Bit period T in clock cycles |
| cfg_start_pol | input | 1 | Level the line moves to on a start edge |
| cfg_sync_bits | input | 4 | Number of leading bits discarded |
| cfg_hdr_len | input | 6 | Header length in bits (0..32) |
| cfg_dat_len | input | 6 | Data length in bits (0..32) |
| cfg_trl_len | input | 6 | Trailer length in bits (0..32) |
| line_in | input | 1 | Serial line |
| frm_valid | output | 1 | One-cycle strobe: field outputs hold a new frame |
| frm_err | output | 1 | One-cycle strobe: Manchester timing violation |
| frm_hdr | output | 32 | Header of the last good frame |
| frm_dat | output | 32 | Data of the last good frame |
| frm_trl | output | 32 | Trailer of the last good frame |

## Verification
The bench drives the layouts with a zero-length header, a zero-length trailer, a 32-bit header and no sync bits. A decoder that mis-skips an empty field would shift bits into the wrong register or hang waiting for bits that never come. Manchester frames are sent with cells both shorter and longer than nominal, and one frame stalls mid-cell. A decoder whose window is off, or that treats cell-boundary edges as data, would flag good frames or decode them wrongly; one that misses the stall would never strobe the error or would corrupt the held outputs. Wrong-direction edges in idle, and an NRZ field of all ones, catch a decoder that starts on any edge or that times out on a steady line.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    localparam int LEN_W   = 6;
    localparam int FIELD_W = 32;

    typedef enum logic {CODE_NRZ = 1'b0, CODE_MAN = 1'b1} code_t;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_SYNC = 3'd1,
        PH_HDR  = 3'd2,
        PH_DAT  = 3'd3,
        PH_TRL  = 3'd4
    } phase_t;

    typedef struct packed {
        logic [LEN_W-1:0] sync_n;
        logic [LEN_W-1:0] hdr_n;
        logic [LEN_W-1:0] dat_n;
        logic [LEN_W-1:0] trl_n;
    } frame_cfg_t;

    typedef struct packed {
        logic [FIELD_W-1:0] hdr;
        logic [FIELD_W-1:0] dat;
        logic [FIELD_W-1:0] trl;
    } field_set_t;

    function automatic logic [LEN_W-1:0] phase_len(phase_t p, frame_cfg_t c);
        case (p)
            PH_SYNC: return c.sync_n;
            PH_HDR:  return c.hdr_n;
            PH_DAT:  return c.dat_n;
            PH_TRL:  return c.trl_n;
            default: return '0;
        endcase
    endfunction

    // First non-empty section after cur; PH_IDLE means the frame is complete.
    function automatic phase_t next_phase(phase_t cur, frame_cfg_t c);
        phase_t r;
        r = PH_IDLE;
        for (int k = 4; k >= 1; k--) begin
            if (k > int'(cur) && phase_len(phase_t'(3'(k)), c) != '0)
                r = phase_t'(3'(k));
        end
        return r;
    endfunction

endpackage

// File: rtl/lcd_line_edge.sv
module lcd_line_edge (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic chg
);
    logic line_q;

    always_ff @(posedge clk) begin
        line_q <= line_in;
    end

    // During reset line_q tracks the line, so no edge is seen at release.
    assign chg = rst ? 1'b0 : (line_in ^ line_q);

endmodule

// File: rtl/lcd_bit_timer.sv
module lcd_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  lcd_pkg::code_t   code,
    input  logic [DIV_W-1:0] div,
    input  logic             active,
    input  logic             start,
    input  logic             chg,
    input  logic             line_lvl,
    output logic             bit_stb,
    output logic             bit_val,
    output logic             tim_err
);
    import lcd_pkg::*;

    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt, period, half, quarter, win_lo, win_hi;
    logic             in_win;

    assign period  = {1'b0, div};
    assign half    = period >> 1;
    assign quarter = period >> 2;
    assign win_lo  = period - quarter;
    assign win_hi  = period + quarter;
    assign in_win  = (cnt >= win_lo) && (cnt <= win_hi);

    always_comb begin
        bit_stb = 1'b0;
        bit_val = 1'b0;
        tim_err = 1'b0;
        if (active) begin
            if (code == CODE_MAN) begin
                if (chg && in_win) begin
                    bit_stb = 1'b1;
                    bit_val = ~line_lvl;       // falling mid-cell -> 1
                end else if (!chg && cnt >= win_hi) begin
                    tim_err = 1'b1;
                end
            end else if (cnt == half) begin
                bit_stb = 1'b1;
                bit_val = line_lvl;
            end
        end
    end

    // Manchester: cnt = cycles since last mid-cell transition (start edge acts as one T/2 earlier).
    // NRZ: cnt = position inside the current cell, re-aligned on every line change.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= (code == CODE_MAN) ? half + 1'b1 : CNT_W'(1);
        end else if (active) begin
            if (code == CODE_MAN)
                cnt <= (chg && in_win) ? CNT_W'(1) : cnt + 1'b1;
            else if (chg)
                cnt <= CNT_W'(1);
            else
                cnt <= (cnt == period - 1'b1) ? '0 : cnt + 1'b1;
        end
    end

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tim_err |=> !tim_err);  // R7

endmodule

// File: rtl/lcd_field_seq.sv
module lcd_field_seq (
    input  logic                clk,
    input  logic                rst,
    input  lcd_pkg::frame_cfg_t cfg,
    input  logic                start,
    input  logic                bit_stb,
    input  logic                bit_val,
    input  logic                tim_err,
    output logic                active,
    output lcd_pkg::field_set_t fields,
    output logic                frm_valid,
    output logic                frm_err
);
    import lcd_pkg::*;

    phase_t           ph, nxt_first, nxt_after;
    logic [LEN_W-1:0] left;
    field_set_t       wk, wk_n;

    assign active    = (ph != PH_IDLE);
    assign nxt_first = next_phase(PH_IDLE, cfg);
    assign nxt_after = next_phase(ph, cfg);

    always_comb begin
        wk_n = wk;
        case (ph)
            PH_HDR:  wk_n.hdr = {wk.hdr[FIELD_W-2:0], bit_val};
            PH_DAT:  wk_n.dat = {wk.dat[FIELD_W-2:0], bit_val};
            PH_TRL:  wk_n.trl = {wk.trl[FIELD_W-2:0], bit_val};
            default: wk_n = wk;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            left      <= '0;
            wk        <= '0;
            fields    <= '0;
            frm_valid <= 1'b0;
            frm_err   <= 1'b0;
        end else begin
            frm_valid <= 1'b0;
            frm_err   <= 1'b0;
            if (ph == PH_IDLE) begin
                if (start) begin
                    wk <= '0;
                    if (nxt_first == PH_IDLE) begin
                        fields    <= '0;
                        frm_valid <= 1'b1;
                    end else begin
                        ph   <= nxt_first;
                        left <= phase_len(nxt_first, cfg);
                    end
                end
            end else if (tim_err) begin
                frm_err <= 1'b1;
                ph      <= PH_IDLE;
            end else if (bit_stb) begin
                wk <= wk_n;
                if (left == LEN_W'(1)) begin
                    ph   <= nxt_after;
                    left <= phase_len(nxt_after, cfg);
                    if (nxt_after == PH_IDLE) begin
                        fields    <= wk_n;
                        frm_valid <= 1'b1;
                    end
                end else begin
                    left <= left - 1'b1;
                end
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> !frm_valid);  // R8
    AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        (frm_valid || frm_err) |-> !active);  // R8
    AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |-> $stable(fields));  // R7

endmodule

// File: rtl/lcd_frame_rx.sv
module lcd_frame_rx #(
    parameter int DIV_W  = 16,
    parameter int SYNC_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_manchester,
    input  logic [DIV_W-1:0]            cfg_baud_div,
    input  logic                        cfg_start_pol,
    input  logic [SYNC_W-1:0]           cfg_sync_bits,
    input  logic [lcd_pkg::LEN_W-1:0]   cfg_hdr_len,
    input  logic [lcd_pkg::LEN_W-1:0]   cfg_dat_len,
    input  logic [lcd_pkg::LEN_W-1:0]   cfg_trl_len,
    input  logic                        line_in,
    output logic                        frm_valid,
    output logic                        frm_err,
    output logic [lcd_pkg::FIELD_W-1:0] frm_hdr,
    output logic [lcd_pkg::FIELD_W-1:0] frm_dat,
    output logic [lcd_pkg::FIELD_W-1:0] frm_trl
);
    import lcd_pkg::*;

    frame_cfg_t cfg;
    field_set_t fields;
    code_t      code;
    logic       chg, start, active, bit_stb, bit_val, tim_err;

    assign code       = code_t'(cfg_manchester);
    assign cfg.sync_n = LEN_W'(cfg_sync_bits);
    assign cfg.hdr_n  = cfg_hdr_len;
    assign cfg.dat_n  = cfg_dat_len;
    assign cfg.trl_n  = cfg_trl_len;
    assign start      = !active && chg && (line_in == cfg_start_pol);

    lcd_line_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_in),
        .chg     (chg)
    );

    lcd_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .code     (code),
        .div      (cfg_baud_div),
        .active   (active),
        .start    (start),
        .chg      (chg),
        .line_lvl (line_in),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .tim_err  (tim_err)
    );

    lcd_field_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .start     (start),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .tim_err   (tim_err),
        .active    (active),
        .fields    (fields),
        .frm_valid (frm_valid),
        .frm_err   (frm_err)
    );

    assign frm_hdr = fields.hdr;
    assign frm_dat = fields.dat;
    assign frm_trl = fields.trl;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(frm_valid && frm_err));  // R8
    AST_NRZ_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_manchester) |-> !frm_err);  // R10

endmodule

// File: tb/lcd_frame_rx_test.sv
module lcd_frame_rx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_manchester = 1'b0;
    logic [15:0] cfg_baud_div = 16'd16;
    logic        cfg_start_pol = 1'b1;
    logic [3:0]  cfg_sync_bits = 4'd0;
    logic [5:0]  cfg_hdr_len = 6'd0, cfg_dat_len = 6'd0, cfg_trl_len = 6'd0;
    logic        line_in = 1'b0;
    logic        frm_valid, frm_err;
    logic [31:0] frm_hdr, frm_dat, frm_trl;

    int n_checks = 0, n_fail = 0, n_val = 0, n_err = 0;

    always #5 clk = ~clk;

    lcd_frame_rx uut (
        .clk(clk), .rst(rst), .cfg_manchester(cfg_manchester), .cfg_baud_div(cfg_baud_div),
        .cfg_start_pol(cfg_start_pol), .cfg_sync_bits(cfg_sync_bits), .cfg_hdr_len(cfg_hdr_len),
        .cfg_dat_len(cfg_dat_len), .cfg_trl_len(cfg_trl_len), .line_in(line_in),
        .frm_valid(frm_valid), .frm_err(frm_err), .frm_hdr(frm_hdr), .frm_dat(frm_dat), .frm_trl(frm_trl)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (frm_valid) n_val++;
            if (frm_err)   n_err++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic lv, input int cyc);
        line_in = lv;
        repeat (cyc) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send_nrz(input logic [127:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) hold(bits[i], int'(cfg_baud_div));
        hold(~cfg_start_pol, 3 * int'(cfg_baud_div));
    endtask

    // h1/h2: cycles of first and second half of each cell; stall_at >= 0 drops that bit's mid transition.
    task automatic send_man(input logic [127:0] bits, input int n, input int h1, input int h2, input int stall_at);
        for (int i = n - 1; i >= 0; i--) begin
            if ((n - 1 - i) == stall_at) begin
                hold(bits[i], 3 * int'(cfg_baud_div));
                break;
            end
            hold(bits[i], h1);
            hold(~bits[i], h2);
        end
        hold(~cfg_start_pol, 3 * int'(cfg_baud_div));
    endtask

    task automatic set_cfg(input logic man, input logic [15:0] div, input logic pol,
                           input logic [3:0] s, input logic [5:0] h, input logic [5:0] d, input logic [5:0] t);
        cfg_manchester = man; cfg_baud_div = div; cfg_start_pol = pol;
        cfg_sync_bits = s; cfg_hdr_len = h; cfg_dat_len = d; cfg_trl_len = t;
    endtask

    task automatic expect_frame(input string tag, input int v0, input int e0,
                                input logic [31:0] eh, input logic [31:0] ed, input logic [31:0] et);
        check(n_val == v0 + 1, {tag, " valid count"}, 32'(n_val - v0), 32'd1);
        check(n_err == e0, {tag, " err count"}, 32'(n_err - e0), 32'd0);
        check(frm_hdr == eh, {tag, " hdr"}, frm_hdr, eh);
        check(frm_dat == ed, {tag, " dat"}, frm_dat, ed);
        check(frm_trl == et, {tag, " trl"}, frm_trl, et);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(frm_valid == 1'b0 && frm_err == 1'b0, "R1 strobes", {frm_valid, frm_err}, 0);
        check(frm_hdr == 0 && frm_dat == 0 && frm_trl == 0, "R1 fields", frm_dat, 0);
    endtask

    task automatic t_nrz_basic;  // R2 R5
        int v0 = n_val, e0 = n_err;
        set_cfg(1'b0, 16'd16, 1'b1, 4'd3, 6'd4, 6'd8, 6'd4);
        send_nrz({3'b101, 4'hA, 8'h5C, 4'h3}, 19);
        expect_frame("R2 nrz", v0, e0, 32'hA, 32'h5C, 32'h3);
    endtask

    task automatic t_man_short;  // R3 R6: 2 sync, no header, 10 data, 1 trailer
        int v0 = n_val, e0 = n_err;
        set_cfg(1'b1, 16'd16, 1'b1, 4'd2, 6'd0, 6'd10, 6'd1);
        send_man({2'b10, 10'h155, 1'b1}, 13, 8, 8, -1);
        expect_frame("R6 man 2/0/10/1", v0, e0, 32'h0, 32'h155, 32'h1);
    endtask

    task automatic t_man_falling;  // R4 R3 R6
        int v0 = n_val, e0 = n_err;
        set_cfg(1'b1, 16'd16, 1'b0, 4'd1, 6'd8, 6'd16, 6'd0);
        hold(1'b1, 64);  // rising edge: opposite direction, ignored
        check(n_val == v0 && n_err == e0, "R4 rising ignored", 32'(n_val - v0 + n_err - e0), 0);
        send_man({1'b0, 8'hC3, 16'hBEEF}, 25, 8, 8, -1);
        expect_frame("R3 man falling start", v0, e0, 32'hC3, 32'hBEEF, 32'h0);
    endtask

    task automatic t_wrong_edge;  // R4 R8
        int v0 = n_val, e0 = n_err;
        set_cfg(1'b1, 16'd16, 1'b1, 4'd2, 6'd4, 6'd8, 6'd2);
        hold(1'b0, 64);  // falling edge with rising start selected
        check(n_val == v0 && n_err == e0, "R4 falling ignored", 32'(n_val - v0 + n_err - e0), 0);
        send_man({2'b11, 4'h9, 8'h3C, 2'b10}, 16, 8, 8, -1);
        expect_frame("R4 frame after ignored edge", v0, e0, 32'h9, 32'h3C, 32'h2);
    endtask

    task automatic t_stall;  // R7
        int v0 = n_val, e0 = n_err;
        send_man({2'b10, 4'h5, 8'hFF, 2'b01}, 16, 8, 8, 6);
        check(n_err == e0 + 1, "R7 err pulse", 32'(n_err - e0), 1);
        check(n_val == v0, "R7 no valid", 32'(n_val - v0), 0);
        check(frm_hdr == 32'h9 && frm_dat == 32'h3C && frm_trl == 32'h2, "R7 fields held", frm_dat, 32'h3C);
    endtask

    task automatic t_after_err;  // R8
        int v0 = n_val, e0 = n_err;
        send_man({2'b11, 4'h6, 8'hA5, 2'b11}, 16, 8, 8, -1);
        expect_frame("R8 frame after error", v0, e0, 32'h6, 32'hA5, 32'h3);
    endtask

    task automatic t_drift;  // R9
        int v0 = n_val, e0 = n_err;
        send_man({2'b10, 4'h3, 8'h71, 2'b00}, 16, 9, 10, -1);
        expect_frame("R9 slow cells", v0, e0, 32'h3, 32'h71, 32'h0);
        v0 = n_val; e0 = n_err;
        send_man({2'b11, 4'hE, 8'h0F, 2'b01}, 16, 6, 7, -1);
        expect_frame("R9 fast cells", v0, e0, 32'hE, 32'h0F, 32'h1);
    endtask

    task automatic t_nrz_long;  // R10 R6 R2
        int v0 = n_val, e0 = n_err;
        set_cfg(1'b0, 16'd10, 1'b1, 4'd1, 6'd32, 6'd16, 6'd3);
        send_nrz({1'b1, 32'hDEADBEEF, 16'hFFFF, 3'b101}, 52);
        expect_frame("R10 nrz 32-bit header, run of ones", v0, e0, 32'hDEADBEEF, 32'hFFFF, 32'h5);
    endtask

    task automatic t_nrz_nosync;  // R5
        int v0 = n_val, e0 = n_err;
        set_cfg(1'b0, 16'd12, 1'b1, 4'd0, 6'd0, 6'd8, 6'd0);
        send_nrz({8'h96}, 8);
        expect_frame("R5 zero sync bits", v0, e0, 32'h0, 32'h96, 32'h0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        @(posedge clk); #1;
        t_nrz_basic();
        t_man_short();
        t_man_falling();
        t_wrong_edge();
        t_stall();
        t_after_err();
        t_drift();
        t_nrz_long();
        t_nrz_nosync();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R8 watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule